// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out 32-bit atomic memory operations on behalf of a simple processor core. The core presents an operation code, a byte address and a register operand. The unit reads the addressed word over a single-port request/response memory interface, computes the updated word, and writes it back to the same address. The word that was in memory before the update goes back to the core as the result.

The memory port may stall a request by holding its ready low, and a read response may arrive any number of cycles after the read is accepted. A lock output stays high from the read request until the write is accepted, so an external arbiter can keep every other master off the memory for the whole sequence. The core sees `busy` while an operation runs and a one-cycle `done` strobe that carries the old word, or the error flag for a rejected request.

Top module: `amo_unit`

## Requirements
- R1: In the `done` cycle of a successful operation, `result` equals the memory word read before the update.
- R2: Operation code 0 (add) stores the old word plus the operand, wrapping modulo 2^32. For example, 0x80000000 + 0xFFFFF800 stores 0x7FFFF800.
- R3: Codes 1, 2 and 3 store the bitwise AND, OR and XOR of the old word and the operand.
- R4: Code 4 (swap) stores the operand unchanged.
- R5: Codes 5 (max) and 6 (min) compare the two words as signed two's-complement values and store the larger or the smaller one.
- R6: Codes 7 (unsigned max) and 8 (unsigned min) compare the two words as unsigned values and store the larger or the smaller one.
- R7: A successful operation makes exactly two memory accesses: a read and then a write to the same address. `mem_lock` is high whenever a memory request is presented and stays high from the read request until the write is accepted.
- R8: Results are correct for any number of stall cycles and any response latency. With S stall cycles on each request and the response L ≥ 1 cycles after the read is accepted, `done` rises 2S+L+2 clock edges after the edge that accepts the request.
- R9: A request whose address bits [1:0] are not zero, or whose code is 9 to 15, makes no memory access. It raises `err` together with `done` one edge after acceptance, and `result` is 0.
- R10: `done` is high for exactly one cycle per accepted request. `busy` is high from the edge that accepts the request through the `done` cycle.
- R11: A request is accepted only while `busy` is low. A `req_valid` presented while busy has no effect on memory or on the running operation.
- R12: After reset, `busy`, `done`, `err`, `mem_req_valid` and `mem_lock` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core presents an atomic request |
| req_op | input | 4 | Operation code (0 add ... 8 unsigned min) |
| req_addr | input | AW | Byte address of the target word |
| req_operand | input | DW | Register operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Request rejected (valid with done) |
| result | output | DW | Old memory word, valid with done |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | AW | Memory request byte address |
| mem_req_wdata | output | DW | Write data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | DW | Read response data |
| mem_lock | output | 1 | Keep other masters off memory |

## Verification
Each operation's completion time is fully set by the bench's own memory stall S and latency L. `done` is due at the falling edge 2S+L+3 half-periods' worth of cycles after acceptance, counted as clock periods from the accepting edge, and one cycle after acceptance for a rejected request. The bench counts falling edges from the accepting edge and checks that count, `result` and the stored word in exactly that cycle. On every falling edge it also compares `busy` with its own expectation and checks that `mem_lock` is high while its memory model holds an open read. The following cycle must show `done` low again.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_SWAP = 4'd4,
    OP_MAX  = 4'd5,
    OP_MIN  = 4'd6,
    OP_MAXU = 4'd7,
    OP_MINU = 4'd8
  } amo_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_DONE    = 3'd4
  } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int LSB = 2
) (
  input  logic [OP_W-1:0] op,
  input  logic [LSB-1:0]  addr_lo,
  output logic            op_legal,
  output logic            aligned,
  output logic            req_ok
);
  function automatic logic f_op_known(input logic [OP_W-1:0] code);
    return code <= OP_LAST;
  endfunction

  function automatic logic f_word_aligned(input logic [LSB-1:0] lo);
    return lo == '0;
  endfunction

  always_comb begin
    op_legal = f_op_known(op);
    aligned  = f_word_aligned(addr_lo);
    req_ok   = op_legal && aligned;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   mem_val,
  input  logic [DW-1:0]   opnd,
  output logic [DW-1:0]   new_val
);
  // Signed order equals unsigned order once both sign bits are inverted.
  function automatic logic [DW-1:0] f_bias(input logic [DW-1:0] v, input logic is_signed);
    return {v[DW-1] ^ is_signed, v[DW-2:0]};
  endfunction

  function automatic logic f_opnd_below(input logic [DW-1:0] m, input logic [DW-1:0] r,
                                        input logic is_signed);
    return f_bias(r, is_signed) < f_bias(m, is_signed);
  endfunction

  function automatic logic [DW-1:0] f_wrap_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW-1:0];
  endfunction

  logic cmp_signed;
  logic r_below;
  logic r_equal;

  always_comb begin
    cmp_signed = (op == OP_MAX) || (op == OP_MIN);
    r_below    = f_opnd_below(mem_val, opnd, cmp_signed);
    r_equal    = (mem_val == opnd);
  end

  always_comb begin
    unique case (op)
      OP_ADD:  new_val = f_wrap_add(mem_val, opnd);
      OP_AND:  new_val = mem_val & opnd;
      OP_OR:   new_val = mem_val | opnd;
      OP_XOR:  new_val = mem_val ^ opnd;
      OP_SWAP: new_val = opnd;
      OP_MAX,
      OP_MAXU: new_val = (r_below || r_equal) ? mem_val : opnd;
      OP_MIN,
      OP_MINU: new_val = r_below ? opnd : mem_val;
      default: new_val = mem_val;
    endcase
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_ok,
  input  logic [OP_W-1:0] req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_operand,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata,
  output logic [OP_W-1:0] op_q,
  output logic [DW-1:0]   old_q,
  output logic [DW-1:0]   operand_q,
  output logic [AW-1:0]   addr_q,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            mem_req_valid,
  output logic            mem_req_we,
  output logic            mem_lock,
  output logic            accept_evt,
  output logic            rd_fire,
  output logic            rsp_fire,
  output logic            wr_fire
);
  amo_state_e state_q, state_d;
  logic       err_q;

  always_comb begin
    accept_evt = (state_q == ST_IDLE)    && req_valid;
    rd_fire    = (state_q == ST_RD_REQ)  && mem_req_ready;
    rsp_fire   = (state_q == ST_RD_WAIT) && mem_rsp_valid;
    wr_fire    = (state_q == ST_WR_REQ)  && mem_req_ready;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_evt) state_d = req_ok ? ST_RD_REQ : ST_DONE;
      ST_RD_REQ:  if (rd_fire)    state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (rsp_fire)   state_d = ST_WR_REQ;
      ST_WR_REQ:  if (wr_fire)    state_d = ST_DONE;
      ST_DONE:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      old_q     <= '0;
      operand_q <= '0;
      addr_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        op_q      <= req_op;
        addr_q    <= req_addr;
        operand_q <= req_operand;
        old_q     <= '0;
        err_q     <= !req_ok;
      end
      if (rsp_fire) old_q <= mem_rsp_rdata;
    end
  end

  always_comb begin
    busy          = (state_q != ST_IDLE);
    done          = (state_q == ST_DONE);
    err           = done && err_q;
    mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    mem_req_we    = (state_q == ST_WR_REQ);
    mem_lock      = (state_q == ST_RD_REQ) || (state_q == ST_RD_WAIT) ||
                    (state_q == ST_WR_REQ);
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [OP_W-1:0] req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_operand,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [DW-1:0]   result,
  output logic            mem_req_valid,
  output logic            mem_req_we,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata,
  output logic            mem_lock
);
  localparam int LSB = $clog2(DW / 8);

  logic            op_legal, aligned, req_ok;
  logic [OP_W-1:0] op_q;
  logic [DW-1:0]   old_q, operand_q, new_val;
  logic [AW-1:0]   addr_q;
  logic            accept_evt, rd_fire, rsp_fire, wr_fire;

  amo_decode #(.LSB(LSB)) u_decode (
    .op       (req_op),
    .addr_lo  (req_addr[LSB-1:0]),
    .op_legal (op_legal),
    .aligned  (aligned),
    .req_ok   (req_ok)
  );

  amo_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ok        (req_ok),
    .req_op        (req_op),
    .req_addr      (req_addr),
    .req_operand   (req_operand),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .op_q          (op_q),
    .old_q         (old_q),
    .operand_q     (operand_q),
    .addr_q        (addr_q),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_lock      (mem_lock),
    .accept_evt    (accept_evt),
    .rd_fire       (rd_fire),
    .rsp_fire      (rsp_fire),
    .wr_fire       (wr_fire)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op      (op_q),
    .mem_val (old_q),
    .opnd    (operand_q),
    .new_val (new_val)
  );

  always_comb begin
    mem_req_addr  = addr_q;
    mem_req_wdata = new_val;
    result        = done ? old_q : '0;
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mem_req_valid,
  input logic          mem_req_we,
  input logic          mem_lock,
  input logic [AW-1:0] mem_req_addr,
  input logic          accept_evt,
  input logic          rsp_fire,
  input logic          wr_fire
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(wr_fire));

  a_r7_req_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_lock);

  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && $past(mem_lock)) |-> $stable(mem_req_addr));

  a_r7_write_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> (mem_req_valid && mem_req_we));

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r9_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $past(accept_evt));

  a_r11_accept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (req_valid && !busy));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_lock && !mem_req_valid && !done));
endmodule

bind amo_unit amo_unit_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .busy          (busy),
  .done          (done),
  .err           (err),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_lock      (mem_lock),
  .mem_req_addr  (mem_req_addr),
  .accept_evt    (accept_evt),
  .rsp_fire      (rsp_fire),
  .wr_fire       (wr_fire)
);

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_operand = '0;
  logic        busy, done, err, mem_req_valid, mem_req_we, mem_lock;
  logic        mem_req_ready, mem_rsp_valid;
  logic [31:0] result, mem_req_wdata, mem_rsp_rdata;
  logic [15:0] mem_req_addr;

  int checks = 0;
  int failures = 0;
  bit exp_busy = 1'b0;
  bit run_chk = 1'b0;

  always #4 clk = ~clk;

  amo_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_operand(req_operand), .busy(busy), .done(done),
    .err(err), .result(result), .mem_req_valid(mem_req_valid),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_lock(mem_lock)
  );

  // Behavioural memory: stalls each request stall_cfg cycles, answers reads lat_cfg later.
  logic [31:0] mem [16];
  int   wait_cnt = 0, stall_cfg = 0, lat_cfg = 1, rsp_cnt = 0, acc_cnt = 0;
  bit   rsp_pend = 1'b0, in_rmw = 1'b0, poke_en = 1'b0;
  int   poke_idx = 0;
  logic [31:0] poke_val = '0, rsp_data = '0;

  assign mem_req_ready = (wait_cnt >= stall_cfg);
  assign mem_rsp_valid = rsp_pend && (rsp_cnt == 1);
  assign mem_rsp_rdata = mem_rsp_valid ? rsp_data : 32'hDEAD_BEEF;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      wait_cnt <= 0; rsp_pend <= 1'b0; in_rmw <= 1'b0; acc_cnt <= 0;
    end else begin
      if (poke_en) mem[poke_idx] <= poke_val;
      if (mem_req_valid && !mem_req_ready) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_req_valid && mem_req_ready) begin
        acc_cnt <= acc_cnt + 1;
        if (mem_req_we) begin
          mem[mem_req_addr[5:2]] <= mem_req_wdata;
          in_rmw <= 1'b0;
        end else begin
          rsp_pend <= 1'b1;
          rsp_cnt  <= lat_cfg;
          rsp_data <= mem[mem_req_addr[5:2]];
          in_rmw   <= 1'b1;
        end
      end else if (rsp_pend) begin
        if (rsp_cnt == 1) rsp_pend <= 1'b0;
        else rsp_cnt <= rsp_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the bench's own view of the transaction.
  always @(negedge clk) begin
    if (run_chk) begin
      chk(busy == exp_busy, "R10 busy", {31'b0, busy}, {31'b0, exp_busy});
      if (in_rmw) chk(mem_lock, "R7 lock open read", {31'b0, mem_lock}, 32'd1);
    end
  end

  function automatic logic [31:0] ref_apply(input logic [3:0] op, input logic [31:0] m,
                                            input logic [31:0] r);
    int sm, sr;
    longint um, ur;
    sm = m; sr = r;
    um = {32'b0, m}; ur = {32'b0, r};
    case (op)
      4'd0: return m + r;
      4'd1: return m & r;
      4'd2: return m | r;
      4'd3: return m ^ r;
      4'd4: return r;
      4'd5: return (sr > sm) ? r : m;
      4'd6: return (sr < sm) ? r : m;
      4'd7: return (ur > um) ? r : m;
      4'd8: return (ur < um) ? r : m;
      default: return m;
    endcase
  endfunction

  task automatic poke(input int idx, input logic [31:0] val);
    @(negedge clk);
    poke_idx = idx; poke_val = val; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic run_op(input logic [3:0] op, input logic [15:0] addr, input logic [31:0] opnd,
                        input int s, input int l, input bit exp_err, input bit hold,
                        input string tag);
    int idx, acc0, cycles, exp_cyc;
    logic [31:0] old_e, new_e;
    idx = int'(addr[5:2]);
    stall_cfg = s; lat_cfg = l;
    old_e = exp_err ? 32'h0 : mem[idx];
    new_e = ref_apply(op, mem[idx], opnd);
    exp_cyc = exp_err ? 1 : 2 * s + l + 3;
    @(negedge clk);
    acc0 = acc_cnt;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_operand = opnd;
    @(posedge clk);
    exp_busy = 1'b1;
    cycles = 0;
    while (1) begin
      @(negedge clk);
      cycles++;
      if (cycles == 1) begin
        if (hold) begin
          req_op = 4'd0; req_addr = 16'h0014; req_operand = 32'h5555_5555;
        end else req_valid = 1'b0;
      end
      if (done || cycles > 400) break;
    end
    req_valid = 1'b0;
    chk(done, "R10 done seen", {31'b0, done}, 32'd1);
    chk(cycles == exp_cyc, "R8 done cycle", cycles, exp_cyc);
    chk(err == exp_err, "R9 err flag", {31'b0, err}, {31'b0, exp_err});
    chk(result == old_e, "R1 old value", result, old_e);
    if (exp_err) chk(acc_cnt == acc0, "R9 no access", acc_cnt, acc0);
    else begin
      chk(acc_cnt == acc0 + 2, "R7 two accesses", acc_cnt, acc0 + 2);
      chk(mem[idx] == new_e, tag, mem[idx], new_e);
    end
    @(posedge clk);
    exp_busy = 1'b0;
    @(negedge clk);
    chk(!done, "R10 single cycle done", {31'b0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk({busy, done, err, mem_req_valid, mem_lock} == 5'b0, "R12 reset outputs",
        {27'b0, busy, done, err, mem_req_valid, mem_lock}, 32'd0);
    run_chk = 1'b1;

    poke(0, 32'h8000_0000);
    run_op(4'd0, 16'h0000, 32'hFFFF_F800, 0, 1, 1'b0, 1'b0, "R2 add wrap");
    run_op(4'd0, 16'h0000, 32'h8000_0000, 3, 6, 1'b0, 1'b0, "R2 add stalled");
    chk(mem[0] == 32'hFFFF_F800, "R2 add value", mem[0], 32'hFFFF_F800);

    poke(1, 32'h8000_0000);
    run_op(4'd1, 16'h0004, 32'hFFFF_F800, 0, 1, 1'b0, 1'b0, "R3 and");
    poke(2, 32'hFFFF_F800);
    run_op(4'd2, 16'h0008, 32'h0000_0001, 1, 2, 1'b0, 1'b0, "R3 or");
    poke(3, 32'h8000_0000);
    run_op(4'd3, 16'h000C, 32'hFFFF_F800, 0, 1, 1'b0, 1'b0, "R3 xor");
    run_op(4'd3, 16'h000C, 32'hC000_0001, 2, 5, 1'b0, 1'b0, "R3 xor stalled");
    chk(mem[3] == 32'hBFFF_F801, "R3 xor value", mem[3], 32'hBFFF_F801);

    poke(4, 32'h8000_0000);
    run_op(4'd4, 16'h0010, 32'hFFFF_F800, 0, 1, 1'b0, 1'b0, "R4 swap");
    run_op(4'd4, 16'h0010, 32'h8000_0000, 4, 9, 1'b0, 1'b0, "R4 swap stalled");

    poke(6, 32'h8000_0000);
    run_op(4'd5, 16'h0018, 32'hFFFF_F800, 0, 1, 1'b0, 1'b0, "R5 max negative");
    chk(mem[6] == 32'hFFFF_F800, "R5 max value", mem[6], 32'hFFFF_F800);
    poke(6, 32'h0);
    run_op(4'd5, 16'h0018, 32'h0000_0001, 1, 3, 1'b0, 1'b0, "R5 max positive");
    poke(7, 32'h8000_0000);
    run_op(4'd6, 16'h001C, 32'hFFFF_F800, 0, 1, 1'b0, 1'b0, "R5 min keeps");
    poke(7, 32'h0);
    run_op(4'd6, 16'h001C, 32'hFFFF_FFFF, 0, 2, 1'b0, 1'b0, "R5 min negative");
    chk(mem[7] == 32'hFFFF_FFFF, "R5 min value", mem[7], 32'hFFFF_FFFF);

    poke(8, 32'h0);
    run_op(4'd7, 16'h0020, 32'hFFFF_FFFF, 0, 1, 1'b0, 1'b0, "R6 maxu");
    chk(mem[8] == 32'hFFFF_FFFF, "R6 maxu value", mem[8], 32'hFFFF_FFFF);
    poke(8, 32'h8000_0000);
    run_op(4'd7, 16'h0020, 32'hFFFF_F800, 2, 1, 1'b0, 1'b0, "R6 maxu high");
    poke(9, 32'h0);
    run_op(4'd8, 16'h0024, 32'hFFFF_FFFF, 0, 1, 1'b0, 1'b0, "R6 minu");
    chk(mem[9] == 32'h0, "R6 minu value", mem[9], 32'h0);
    poke(9, 32'h8000_0000);
    run_op(4'd8, 16'h0024, 32'hFFFF_F800, 1, 7, 1'b0, 1'b0, "R6 minu high");

    // R9: misaligned and unknown code
    run_op(4'd0, 16'h0026, 32'h0000_0001, 0, 1, 1'b1, 1'b0, "R9 misaligned");
    chk(mem[9] == 32'h8000_0000, "R9 word untouched", mem[9], 32'h8000_0000);
    run_op(4'd12, 16'h0024, 32'h0000_0001, 0, 1, 1'b1, 1'b0, "R9 bad code");

    // R11: request held during busy with a different target is ignored
    poke(5, 32'h0000_1234);
    poke(10, 32'h0000_0042);
    run_op(4'd4, 16'h0028, 32'hCAFE_0000, 2, 4, 1'b0, 1'b1, "R11 swap while held");
    chk(mem[5] == 32'h0000_1234, "R11 held request ignored", mem[5], 32'h0000_1234);
    chk(!busy, "R11 idle after", {31'b0, busy}, 32'd0);

    run_chk = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule